// File: doc/BRIEF.md
# Transfer-Controller Activation Source Control

This block decides, for every pending peripheral request, whether it starts a data-transfer-controller transfer or goes to the CPU interrupt path. Each source has an enable bit. A source with its bit at 1 is routed to the transfer engine, and the CPU mask level plays no part in that routing. A source with its bit at 0 goes straight through to the CPU request lines. A software activation request has its own enable bit. It joins the same arbitration as the lowest-priority entry.

When one or more enabled sources are pending and no transfer is in flight, the block issues a single-cycle start pulse with the index of the winner, then waits. The transfer engine returns a done pulse carrying two status bits: whether the transfer was marked to disable its source afterwards, and whether its programmed count has run out. These bits decide what happens next. The block either clears the source flag and keeps the enable bit, so the CPU never hears of the event, or it clears the enable bit and leaves the flag set, so the request falls through to the CPU. A serial receive-complete source would connect its receive-data-full flag to `src_flag`.

Top module: `act_src_ctrl`

## Requirements
- R1: After reset, `en_o`, `sw_en_o`, `sw_irq`, `xfer_start` and `busy` are all 0.
- R2: When a source is pending with its enable bit at 1 and the block is idle, `xfer_start` is high for exactly one cycle, on the second clock edge after the flag and enable bit are both seen. `xfer_idx` carries the source number at that point, and `busy` rises with it.
- R3: Among simultaneous eligible requests, the lowest source index wins. The software request uses index N_SRC (8 by default) and loses to every hardware source.
- R4: While `busy` is 1, no further `xfer_start` is issued. The next eligible request starts on the second edge after the done cycle.
- R5: A done pulse with `done_disable`=0 and `done_cnt_end`=0 pulses `flag_clr` at the active index in the same cycle. `en_clr` stays 0, the enable bit stays 1 and `cpu_irq` stays 0 for that source.
- R6: A done pulse with `done_disable`=1 or `done_cnt_end`=1 pulses `en_clr` at the active index in the same cycle, leaves `flag_clr` at 0 and clears the enable bit at the edge, so `cpu_irq` shows the still-pending flag.
- R7: `cpu_irq` equals `src_flag` AND NOT `en_o`, without delay. A disabled source never starts a transfer.
- R8: Writing `sw_wdata`=1 with `sw_wr` sets `sw_en_o` and leads to a start at index N_SRC. A normal done on it clears `sw_en_o`, keeps `sw_irq` at 0 and pulses no `flag_clr` bit.
- R9: A software transfer ending with disable or count-ended keeps `sw_en_o` at 1, raises `sw_irq`, and starts nothing more. Writing 0 through `sw_wr` clears both.
- R10: `xfer_done` while idle is ignored: no `flag_clr` or `en_clr` pulse, and the enable register is unchanged.
- R11: `cfg_we` loads `cfg_wdata` into the enable register at the edge. An `en_clr` in the same cycle takes precedence on its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | N_SRC | Pending flags from peripherals |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | N_SRC | Enable register write value |
| sw_wr | input | 1 | Software enable write strobe |
| sw_wdata | input | 1 | Software enable write value |
| xfer_done | input | 1 | Transfer finished pulse |
| done_disable | input | 1 | Finished transfer had its disable bit set |
| done_cnt_end | input | 1 | Finished transfer exhausted its count |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| xfer_idx | output | SEL_W | Active source index (N_SRC = software) |
| busy | output | 1 | Transfer in flight |
| flag_clr | output | N_SRC | Source flag clear pulses |
| en_clr | output | N_SRC | Enable-bit clear pulses |
| en_o | output | N_SRC | Enable register |
| sw_en_o | output | 1 | Software enable bit |
| cpu_irq | output | N_SRC | Requests forwarded to the CPU |
| sw_irq | output | 1 | Software activation interrupt to the CPU |

## Verification
A wrong priority or a stale index shows up in `xfer_idx` on the same edge as the start pulse. A mixed-up disable/count decode shows up during the done cycle as a pulse on the wrong clear vector. A bad enable update is visible one edge later on `en_o` and `cpu_irq`. A stuck busy state shows up two edges after a done, when a known pending source fails to start.

// File: rtl/act_pkg.sv
package act_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } act_state_e;

endpackage

// File: rtl/act_prio_pick.sv
// Fixed-priority selection: lowest hardware index first, software request last.
module act_prio_pick #(
    parameter int N_SRC = 8,
    parameter int SEL_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0] req,
    input  logic             sw_req,
    output logic             valid,
    output logic [SEL_W-1:0] idx
);

    logic [N_SRC-1:0] grant;
    logic [SEL_W-1:0] enc;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_grant
            if (gi == 0) begin : g_top
                assign grant[gi] = req[gi];
            end else begin : g_rest
                assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
            end
        end
    endgenerate

    always_comb begin
        enc = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) begin
                enc = enc | SEL_W'(i);
            end
        end
    end

    assign valid = (|req) | sw_req;
    assign idx   = (|req) ? enc : SEL_W'(N_SRC);

endmodule

// File: rtl/act_bypass.sv
// Requests of disabled sources go straight to the CPU.
module act_bypass #(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] en,
    output logic [N_SRC-1:0] irq,
    output logic [N_SRC-1:0] eligible
);

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_route
            assign irq[gi]      = flag[gi] & ~en[gi];
            assign eligible[gi] = flag[gi] &  en[gi];
        end
    endgenerate

endmodule

// File: rtl/act_clr_decode.sv
// Turns a completed transfer into flag-clear or enable-clear pulses.
module act_clr_decode #(
    parameter int N_SRC = 8,
    parameter int SEL_W = $clog2(N_SRC + 1)
) (
    input  logic             done_ok,
    input  logic             stop,
    input  logic [SEL_W-1:0] idx,
    output logic [N_SRC-1:0] flag_clr,
    output logic [N_SRC-1:0] en_clr,
    output logic             sw_norm,
    output logic             sw_stop
);

    logic sw_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_dec
            logic hit;
            assign hit          = done_ok && (idx == SEL_W'(gi));
            assign flag_clr[gi] = hit & ~stop;
            assign en_clr[gi]   = hit &  stop;
        end
    endgenerate

    assign sw_hit  = done_ok && (idx == SEL_W'(N_SRC));
    assign sw_norm = sw_hit & ~stop;
    assign sw_stop = sw_hit &  stop;

endmodule

// File: rtl/act_src_ctrl.sv
module act_src_ctrl #(
    parameter int N_SRC = 8,
    parameter int SEL_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_flag,
    input  logic             cfg_we,
    input  logic [N_SRC-1:0] cfg_wdata,
    input  logic             sw_wr,
    input  logic             sw_wdata,
    input  logic             xfer_done,
    input  logic             done_disable,
    input  logic             done_cnt_end,
    output logic             xfer_start,
    output logic [SEL_W-1:0] xfer_idx,
    output logic             busy,
    output logic [N_SRC-1:0] flag_clr,
    output logic [N_SRC-1:0] en_clr,
    output logic [N_SRC-1:0] en_o,
    output logic             sw_en_o,
    output logic [N_SRC-1:0] cpu_irq,
    output logic             sw_irq
);
    import act_pkg::*;

    typedef struct packed {
        act_state_e       st;
        logic [N_SRC-1:0] en;
        logic             sw_en;
        logic             sw_hold;
        logic [SEL_W-1:0] idx;
        logic             start;
    } ctrl_t;

    ctrl_t q, d;

    logic [N_SRC-1:0] eligible;
    logic             pick_valid;
    logic [SEL_W-1:0] pick_idx;
    logic             done_ok;
    logic             stop;
    logic             sw_norm;
    logic             sw_stop;

    act_bypass #(.N_SRC(N_SRC)) u_bypass (
        .flag     (src_flag),
        .en       (q.en),
        .irq      (cpu_irq),
        .eligible (eligible)
    );

    act_prio_pick #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_pick (
        .req    (eligible),
        .sw_req (q.sw_en & ~q.sw_hold),
        .valid  (pick_valid),
        .idx    (pick_idx)
    );

    assign done_ok = xfer_done && (q.st == ST_BUSY);
    assign stop    = done_disable | done_cnt_end;

    act_clr_decode #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_dec (
        .done_ok  (done_ok),
        .stop     (stop),
        .idx      (q.idx),
        .flag_clr (flag_clr),
        .en_clr   (en_clr),
        .sw_norm  (sw_norm),
        .sw_stop  (sw_stop)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (cfg_we) begin
            d.en = cfg_wdata;
        end
        if (sw_wr) begin
            d.sw_en   = sw_wdata;
            d.sw_hold = 1'b0;
        end
        case (q.st)
            ST_IDLE: begin
                if (pick_valid) begin
                    d.st    = ST_BUSY;
                    d.start = 1'b1;
                    d.idx   = pick_idx;
                end
            end
            default: begin
                if (done_ok) begin
                    d.st = ST_IDLE;
                    d.en = d.en & ~en_clr;
                    if (sw_norm) begin
                        d.sw_en = 1'b0;
                    end
                    if (sw_stop) begin
                        d.sw_en   = 1'b1;
                        d.sw_hold = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.en      <= '0;
            q.sw_en   <= 1'b0;
            q.sw_hold <= 1'b0;
            q.idx     <= '0;
            q.start   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign xfer_start = q.start;
    assign xfer_idx   = q.idx;
    assign busy       = (q.st == ST_BUSY);
    assign en_o       = q.en;
    assign sw_en_o    = q.sw_en;
    assign sw_irq     = q.sw_hold;

endmodule

// File: rtl/act_src_ctrl_chk.sv
module act_src_ctrl_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic             busy,
    input logic             cfg_we,
    input logic [N_SRC-1:0] flag_clr,
    input logic [N_SRC-1:0] en_clr,
    input logic [N_SRC-1:0] en_o,
    input logic [N_SRC-1:0] cpu_irq
);

    // R2: a start comes with busy rising and lasts one cycle
    a_r2_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $rose(busy));
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R5: at most one flag clear at a time, never together with an enable clear
    a_r5_one_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr));
    a_r5_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr & en_clr) == '0);
    a_r5_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flag_clr) && !cfg_we) |=> ((en_o & $past(flag_clr)) == $past(flag_clr)));

    // R6 and R11: an enable clear always lands
    a_r6_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |=> ((en_o & $past(en_clr)) == '0));

    // R7: an enabled source never reaches the CPU lines
    a_r7_no_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq & en_o) == '0);

    // R10: no clear pulse without a transfer in flight
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flag_clr == '0 && en_clr == '0));

endmodule

bind act_src_ctrl act_src_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .busy       (busy),
    .cfg_we     (cfg_we),
    .flag_clr   (flag_clr),
    .en_clr     (en_clr),
    .en_o       (en_o),
    .cpu_irq    (cpu_irq)
);

// File: tb/tb_act_src_ctrl.sv
module tb_act_src_ctrl;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int SW    = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  flags;
    logic [N-1:0]  tb_set = '0;
    logic [N-1:0]  tb_clr = '0;
    logic          cfg_we = 1'b0;
    logic [N-1:0]  cfg_wdata = '0;
    logic          sw_wr = 1'b0;
    logic          sw_wdata = 1'b0;
    logic          xfer_done = 1'b0;
    logic          done_disable = 1'b0;
    logic          done_cnt_end = 1'b0;
    logic          xfer_start;
    logic [SW-1:0] xfer_idx;
    logic          busy;
    logic [N-1:0]  flag_clr;
    logic [N-1:0]  en_clr;
    logic [N-1:0]  en_o;
    logic          sw_en_o;
    logic [N-1:0]  cpu_irq;
    logic          sw_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    // peripheral flag model: set by bench, cleared by the block or bench
    always @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr & ~tb_clr) | tb_set;
    end

    act_src_ctrl #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_flag(flags),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .xfer_done(xfer_done), .done_disable(done_disable), .done_cnt_end(done_cnt_end),
        .xfer_start(xfer_start), .xfer_idx(xfer_idx), .busy(busy),
        .flag_clr(flag_clr), .en_clr(en_clr), .en_o(en_o), .sw_en_o(sw_en_o),
        .cpu_irq(cpu_irq), .sw_irq(sw_irq)
    );

    // {enable, flags, expected winner}
    localparam logic [2*N+SW-1:0] TBL [6] = '{
        {8'hFF, 8'h01, 4'd0},
        {8'hFF, 8'h80, 4'd7},
        {8'hFF, 8'hA4, 4'd2},
        {8'hF0, 8'h1F, 4'd4},
        {8'hFF, 8'hC0, 4'd6},
        {8'h0F, 8'h08, 4'd3}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        cfg_we = 1'b0; tb_set = '0; tb_clr = '0; sw_wr = 1'b0;
        xfer_done = 1'b0; done_disable = 1'b0; done_cnt_end = 1'b0;
    endtask

    task automatic wipe();
        cfg_we = 1'b1; cfg_wdata = '0; tb_clr = '1;
        step();
        quiet();
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(xfer_start == 0 && busy == 0, "R1", {xfer_start, busy}, 0);
        chk(en_o == 0 && sw_en_o == 0 && sw_irq == 0, "R1", {en_o, sw_en_o, sw_irq}, 0);

        // table: priority and basic start/normal completion
        foreach (TBL[k]) begin
            logic [N-1:0]  t_en;
            logic [N-1:0]  t_rq;
            logic [SW-1:0] t_ix;
            {t_en, t_rq, t_ix} = TBL[k];
            cfg_we = 1'b1; cfg_wdata = t_en; tb_set = t_rq;
            step();
            quiet();
            chk(cpu_irq == (t_rq & ~t_en), "R7", cpu_irq, t_rq & ~t_en);
            step();
            chk(xfer_start == 1 && busy == 1, "R2", {xfer_start, busy}, 2'b11);
            chk(xfer_idx == t_ix, "R3", xfer_idx, t_ix);
            step();
            chk(xfer_start == 0, "R2", xfer_start, 0);
            xfer_done = 1'b1;
            #1;
            chk(flag_clr == (N'(1) << t_ix) && en_clr == 0, "R5", flag_clr, N'(1) << t_ix);
            cfg_we = 1'b1; cfg_wdata = '0; tb_clr = '1;
            step();
            quiet();
            chk(busy == 0, "R4", busy, 0);
        end

        // R7: disabled source never starts
        tb_set = 8'h10;
        step(); quiet();
        chk(cpu_irq == 8'h10, "R7", cpu_irq, 8'h10);
        step(); step();
        chk(xfer_start == 0 && busy == 0, "R7", {xfer_start, busy}, 0);
        wipe();

        // R4/R5: second source waits for done; enable kept
        cfg_we = 1'b1; cfg_wdata = 8'h03; tb_set = 8'h03;
        step(); quiet();
        step();
        chk(xfer_start && xfer_idx == 0, "R4", xfer_idx, 0);
        step(); step(); step();
        chk(xfer_start == 0 && busy == 1, "R4", {xfer_start, busy}, 2'b01);
        xfer_done = 1'b1;
        #1;
        chk(flag_clr == 8'h01, "R5", flag_clr, 8'h01);
        step(); quiet();
        chk(en_o == 8'h03 && cpu_irq == 0, "R5", {en_o, cpu_irq}, {8'h03, 8'h00});
        chk(flags == 8'h02, "R5", flags, 8'h02);
        step();
        chk(xfer_start && xfer_idx == 1, "R4", xfer_idx, 1);
        step();
        xfer_done = 1'b1;
        step(); quiet();
        chk(flags == 0 && en_o == 8'h03, "R5", {flags, en_o}, {8'h00, 8'h03});
        wipe();

        // R6: disable bit set
        cfg_we = 1'b1; cfg_wdata = 8'h02; tb_set = 8'h02;
        step(); quiet();
        step();
        chk(xfer_start && xfer_idx == 1, "R2", xfer_idx, 1);
        step();
        xfer_done = 1'b1; done_disable = 1'b1;
        #1;
        chk(en_clr == 8'h02 && flag_clr == 0, "R6", {en_clr, flag_clr}, {8'h02, 8'h00});
        step(); quiet();
        chk(en_o == 0 && cpu_irq == 8'h02 && busy == 0, "R6", {en_o, cpu_irq}, {8'h00, 8'h02});
        step();
        chk(xfer_start == 0, "R6", xfer_start, 0);
        wipe();

        // R6/R11: count ended, simultaneous enable write
        cfg_we = 1'b1; cfg_wdata = 8'h08; tb_set = 8'h08;
        step(); quiet();
        step();
        chk(xfer_start && xfer_idx == 3, "R2", xfer_idx, 3);
        step();
        xfer_done = 1'b1; done_cnt_end = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'hFF;
        #1;
        chk(en_clr == 8'h08, "R6", en_clr, 8'h08);
        step(); quiet();
        chk(en_o == 8'hF7 && cpu_irq == 8'h08, "R11", {en_o, cpu_irq}, {8'hF7, 8'h08});
        wipe();

        // R10: done while idle
        cfg_we = 1'b1; cfg_wdata = 8'h0F;
        step(); quiet();
        xfer_done = 1'b1; done_disable = 1'b1;
        #1;
        chk(en_clr == 0 && flag_clr == 0, "R10", {en_clr, flag_clr}, 0);
        step(); quiet();
        chk(en_o == 8'h0F && busy == 0, "R10", en_o, 8'h0F);
        wipe();

        // R3/R8: software loses to a hardware source, then runs normally
        cfg_we = 1'b1; cfg_wdata = 8'h20; tb_set = 8'h20; sw_wr = 1'b1; sw_wdata = 1'b1;
        step(); quiet();
        chk(sw_en_o == 1, "R8", sw_en_o, 1);
        step();
        chk(xfer_start && xfer_idx == 5, "R3", xfer_idx, 5);
        step();
        xfer_done = 1'b1;
        step(); quiet();
        step();
        chk(xfer_start && xfer_idx == SW'(N), "R3", xfer_idx, N);
        step();
        xfer_done = 1'b1;
        #1;
        chk(flag_clr == 0, "R8", flag_clr, 0);
        step(); quiet();
        chk(sw_en_o == 0 && sw_irq == 0, "R8", {sw_en_o, sw_irq}, 0);
        step();
        chk(xfer_start == 0, "R8", xfer_start, 0);

        // R9: software with disable bit
        sw_wr = 1'b1; sw_wdata = 1'b1;
        step(); quiet();
        step();
        chk(xfer_start && xfer_idx == SW'(N), "R9", xfer_idx, N);
        step();
        xfer_done = 1'b1; done_disable = 1'b1;
        step(); quiet();
        chk(sw_en_o == 1 && sw_irq == 1, "R9", {sw_en_o, sw_irq}, 2'b11);
        step(); step();
        chk(xfer_start == 0 && busy == 0, "R9", {xfer_start, busy}, 0);
        sw_wr = 1'b1; sw_wdata = 1'b0;
        step(); quiet();
        chk(sw_en_o == 0 && sw_irq == 0, "R9", {sw_en_o, sw_irq}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule